// File: doc/BRIEF.md
# PSK Symbol Mapper and Differential Encoder

This block sits at the front of a digital phase-shift-keyed transmitter. It takes a serial bit stream one bit per bit-clock enable and groups the bits into symbols. A symbol is a single bit in BPSK mode, or an (I, Q) bit pair in QPSK mode. It can then apply differential encoding and presents each finished symbol as an I/Q bit pair with a one-cycle valid strobe, ready for a pulse-shaping filter.

For link testing, an internal pseudo-random generator can take the place of the serial input. It offers a short sequence and a long sequence. Bits are accepted only while the data enable is high. Differential encoding restarts against a zero reference whenever it is switched on, so that the receiver can resynchronise at the start of a burst.

Top module: `psk_symbol_encoder`

## Requirements
- R1: While reset is low, and in the first cycle after it, symValid, symI and symQ are 0.
- R2: In BPSK mode (bpskMode=1), every cycle with bitStrobe=1 and burstEnable=1 produces one symbol, with symValid high for exactly the following cycle and symQ=0 for that symbol.
- R3: In QPSK mode (bpskMode=0), two accepted bits make one symbol. The first bit is I and the second is Q, and the symbol appears in the cycle after the second bit. A cycle with burstEnable=0 throws away a half-formed pair.
- R4: bitStrobe has no effect while burstEnable=0. symValid never rises without an accepted bit, and in QPSK two consecutive cycles never both carry symValid.
- R5: With diffEnable=0 at the bit that completes a symbol, the symbol is output unchanged (in BPSK, symI equals the accepted bit).
- R6: DBPSK (bpskMode=1, diffEnable=1): the output bit is the input bit XOR the previously output bit.
- R7: The differential reference is forced to 0 (00 in QPSK) for the first symbol completed with diffEnable=1 after a symbol completed with diffEnable=0, or after reset.
- R8: DQPSK (bpskMode=0, diffEnable=1): (I,Q) maps to a phase step as 00=0, 01=1, 11=2 and 10=3 quarter turns. The output is the previous output's phase plus the input's step, modulo four, mapped back through the same code.
- R9: With pnEnable=1 and pnLongSel=0, the source bit is a 10-stage shift register. It is seeded with all ones at reset. Its output is stage 10, and stage 10 XOR stage 3 shifts into stage 1 each time a bit is accepted.
- R10: With pnEnable=1 and pnLongSel=1, a 23-stage register with feedback from stages 23 and 18, built the same way, supplies the bits. Each register advances only when a bit it supplies is accepted, and the serial input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serialBit | input | 1 | Serial transmit bit |
| bitStrobe | input | 1 | Bit-clock enable, one pulse per bit |
| burstEnable | input | 1 | Data enable; bits accepted only while high |
| diffEnable | input | 1 | Differential encoding on |
| bpskMode | input | 1 | 1 = BPSK, 0 = QPSK |
| pnEnable | input | 1 | Replace serial input with PN source |
| pnLongSel | input | 1 | 0 = 10-stage PN, 1 = 23-stage PN |
| symValid | output | 1 | One-cycle strobe per symbol |
| symI | output | 1 | Symbol I bit |
| symQ | output | 1 | Symbol Q bit |

## Verification
Every symbol appears exactly one clock after the accepted bit that completes it: the first bit of a QPSK pair gives no output, and the second bit gives the symbol in the next cycle. The symbol bits then hold until the next symbol. The bench changes inputs on the falling edge and uses a behavioural model to predict the registered outputs after the next rising edge. It compares the outputs on the following falling edge, so each comparison falls exactly one register stage after its stimulus. PN sequences are predicted from the polynomial alone, with a step only on accepted bits, so a stall or an extra step shows up as a mismatch.

// File: rtl/psk_enc_pkg.sv
package psk_enc_pkg;

  typedef struct packed {
    logic captureI;  // first bit of a QPSK pair arrives
    logic symDone;   // a symbol completes this cycle
    logic restart;   // differential reference forced to zero
    logic pnStep;    // PN source delivers an accepted bit
  } encStrobes_t;

  // Gray-coded quarter-turn index of an (I,Q) pair
  function automatic logic [1:0] bitsToPhase(input logic iBit, input logic qBit);
    return {iBit, iBit ^ qBit};
  endfunction

  function automatic logic [1:0] phaseToBits(input logic [1:0] ph);
    return {ph[1], ph[1] ^ ph[0]};
  endfunction

endpackage

// File: rtl/psk_pn_lfsr.sv
module psk_pn_lfsr #(
  parameter int LEN = 10,
  parameter int TAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic outBit
);
  localparam int MSB = LEN - 1;

  logic [MSB:0] stages;
  logic feedback;

  assign outBit   = stages[MSB];
  assign feedback = stages[MSB] ^ stages[TAP-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stages <= '1;
    else if (step) stages <= {stages[MSB-1:0], feedback};
  end
endmodule

// File: rtl/psk_enc_ctrl.sv
module psk_enc_ctrl
  import psk_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitStrobe,
  input  logic        burstEnable,
  input  logic        diffEnable,
  input  logic        bpskMode,
  input  logic        pnEnable,
  output encStrobes_t strobes
);
  logic consume;
  logic pairPhase;
  logic diffActive;

  assign consume = bitStrobe & burstEnable;

  always_comb begin
    strobes          = '0;
    strobes.pnStep   = consume & pnEnable;
    if (bpskMode) begin
      strobes.symDone = consume;
    end else begin
      strobes.captureI = consume & ~pairPhase;
      strobes.symDone  = consume & pairPhase;
    end
    strobes.restart = strobes.symDone & diffEnable & ~diffActive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pairPhase  <= 1'b0;
      diffActive <= 1'b0;
    end else begin
      if (!burstEnable || bpskMode) pairPhase <= 1'b0;
      else if (consume)             pairPhase <= ~pairPhase;
      if (strobes.symDone)          diffActive <= diffEnable;
    end
  end
endmodule

// File: rtl/psk_enc_datapath.sv
module psk_enc_datapath
  import psk_enc_pkg::*;
#(
  parameter int SHORT_LEN = 10,
  parameter int SHORT_TAP = 3,
  parameter int LONG_LEN  = 23,
  parameter int LONG_TAP  = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  encStrobes_t strobes,
  input  logic        serialBit,
  input  logic        diffEnable,
  input  logic        bpskMode,
  input  logic        pnEnable,
  input  logic        pnLongSel,
  output logic        symValid,
  output logic        symI,
  output logic        symQ
);
  logic shortBit, longBit, srcBit;
  logic holdI;
  logic prevI, prevQ;
  logic inI, inQ, refI, refQ, encI, encQ;
  logic [1:0] sumPhase;

  psk_pn_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP)) shortGen_i (
    .clk(clk), .rst_n(rst_n), .step(strobes.pnStep & ~pnLongSel), .outBit(shortBit)
  );

  psk_pn_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP)) longGen_i (
    .clk(clk), .rst_n(rst_n), .step(strobes.pnStep & pnLongSel), .outBit(longBit)
  );

  assign srcBit = pnEnable ? (pnLongSel ? longBit : shortBit) : serialBit;

  always_comb begin
    inI  = bpskMode ? srcBit : holdI;
    inQ  = bpskMode ? 1'b0   : srcBit;
    refI = strobes.restart ? 1'b0 : prevI;
    refQ = strobes.restart ? 1'b0 : prevQ;
    sumPhase = bitsToPhase(inI, inQ) + bitsToPhase(refI, refQ);
    if (!diffEnable) begin
      encI = inI;
      encQ = inQ;
    end else if (bpskMode) begin
      encI = inI ^ refI;
      encQ = 1'b0;
    end else begin
      {encI, encQ} = phaseToBits(sumPhase);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdI    <= 1'b0;
      prevI    <= 1'b0;
      prevQ    <= 1'b0;
      symValid <= 1'b0;
      symI     <= 1'b0;
      symQ     <= 1'b0;
    end else begin
      symValid <= strobes.symDone;
      if (strobes.captureI) holdI <= srcBit;
      if (strobes.symDone) begin
        prevI <= encI;
        prevQ <= encQ;
        symI  <= encI;
        symQ  <= encQ;
      end
    end
  end
endmodule

// File: rtl/psk_symbol_encoder.sv
module psk_symbol_encoder
  import psk_enc_pkg::*;
#(
  parameter int SHORT_LEN = 10,
  parameter int SHORT_TAP = 3,
  parameter int LONG_LEN  = 23,
  parameter int LONG_TAP  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serialBit,
  input  logic bitStrobe,
  input  logic burstEnable,
  input  logic diffEnable,
  input  logic bpskMode,
  input  logic pnEnable,
  input  logic pnLongSel,
  output logic symValid,
  output logic symI,
  output logic symQ
);
  encStrobes_t strobes;

  psk_enc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .bitStrobe(bitStrobe), .burstEnable(burstEnable),
    .diffEnable(diffEnable), .bpskMode(bpskMode), .pnEnable(pnEnable),
    .strobes(strobes)
  );

  psk_enc_datapath #(
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
    .LONG_LEN(LONG_LEN), .LONG_TAP(LONG_TAP)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .serialBit(serialBit),
    .diffEnable(diffEnable), .bpskMode(bpskMode), .pnEnable(pnEnable),
    .pnLongSel(pnLongSel), .symValid(symValid), .symI(symI), .symQ(symQ)
  );
endmodule

// File: rtl/psk_symbol_encoder_chk.sv
module psk_symbol_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic serialBit,
  input logic bitStrobe,
  input logic burstEnable,
  input logic diffEnable,
  input logic bpskMode,
  input logic pnEnable,
  input logic symValid,
  input logic symQ
);
  p_bpsk_symbol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bitStrobe && burstEnable && bpskMode) |=> (symValid && !symQ));

  p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bitStrobe && burstEnable) |=> !symValid);

  p_qpsk_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (symValid && !bpskMode) |=> !symValid);

  p_passthrough_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bitStrobe && burstEnable && bpskMode && !diffEnable && !pnEnable)
      |=> (dut_sym_i_helper == $past(serialBit)));

  logic dut_sym_i_helper;
  assign dut_sym_i_helper = psk_symbol_encoder.symI;

  always_ff @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!symValid);
  end
endmodule

bind psk_symbol_encoder psk_symbol_encoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .serialBit(serialBit), .bitStrobe(bitStrobe),
  .burstEnable(burstEnable), .diffEnable(diffEnable), .bpskMode(bpskMode),
  .pnEnable(pnEnable), .symValid(symValid), .symQ(symQ)
);

// File: tb/psk_symbol_encoder_tb.sv
module psk_symbol_encoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serialBit = 0, bitStrobe = 0, burstEnable = 0, diffEnable = 0;
  logic bpskMode = 1, pnEnable = 0, pnLongSel = 0;
  logic symValid, symI, symQ;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psk_symbol_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .serialBit(serialBit), .bitStrobe(bitStrobe),
    .burstEnable(burstEnable), .diffEnable(diffEnable), .bpskMode(bpskMode),
    .pnEnable(pnEnable), .pnLongSel(pnLongSel),
    .symValid(symValid), .symI(symI), .symQ(symQ)
  );

  // reference model state
  int mPair = 0, mHoldI = 0, mDiffActive = 0, mPrevI = 0, mPrevQ = 0;
  int mShort = 'h3FF, mLong = 'h7FFFFF;
  int expV = 0, expI = 0, expQ = 0;
  string expTag = "R1";

  function automatic int g2p(int i, int q);
    case ({i[0], q[0]})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int p2gI(int p);
    return (p == 2 || p == 3) ? 1 : 0;
  endfunction

  function automatic int p2gQ(int p);
    return (p == 1 || p == 2) ? 1 : 0;
  endfunction

  function automatic int lfsrOut(int s, int len);
    return (s >> (len - 1)) & 1;
  endfunction

  function automatic int lfsrNext(int s, int len, int tap);
    int fb = ((s >> (len - 1)) ^ (s >> (tap - 1))) & 1;
    return ((s << 1) | fb) & ((1 << len) - 1);
  endfunction

  task automatic compare();
    checks++;
    if (symValid !== expV[0] || symI !== expI[0] || symQ !== expQ[0]) begin
      failures++;
      $display("FAIL %s: actual v=%0b i=%0b q=%0b expected v=%0d i=%0d q=%0d",
               expTag, symValid, symI, symQ, expV, expI, expQ);
    end
  endtask

  // one cycle: check previous prediction, apply new inputs, predict next outputs
  task automatic step(input bit s, input bit st, input bit be, input bit de,
                      input bit bp, input bit pe, input bit pl, input string tag);
    int src, inI, inQ, refI, refQ, oI, oQ;
    bit acc, fin;
    @(negedge clk);
    compare();
    serialBit = s; bitStrobe = st; burstEnable = be; diffEnable = de;
    bpskMode = bp; pnEnable = pe; pnLongSel = pl;
    acc = st && be;
    src = pe ? (pl ? lfsrOut(mLong, 23) : lfsrOut(mShort, 10)) : int'(s);
    if (acc && pe) begin
      if (pl) mLong = lfsrNext(mLong, 23, 18);
      else    mShort = lfsrNext(mShort, 10, 3);
    end
    fin = 0; inI = 0; inQ = 0;
    if (acc) begin
      if (bp) begin fin = 1; inI = src; end
      else if (mPair == 0) begin mHoldI = src; end
      else begin fin = 1; inI = mHoldI; inQ = src; end
    end
    if (!be || bp) mPair = 0;
    else if (acc) mPair = 1 - mPair;
    expV = fin;
    expTag = tag;
    if (fin) begin
      refI = (de && !mDiffActive) ? 0 : mPrevI;
      refQ = (de && !mDiffActive) ? 0 : mPrevQ;
      if (!de) begin oI = inI; oQ = inQ; end
      else if (bp) begin oI = inI ^ refI; oQ = 0; end
      else begin
        oI = p2gI((g2p(inI, inQ) + g2p(refI, refQ)) % 4);
        oQ = p2gQ((g2p(inI, inQ) + g2p(refI, refQ)) % 4);
      end
      mPrevI = oI; mPrevQ = oQ; mDiffActive = de;
      expI = oI; expQ = oQ;
    end
  endtask

  task automatic phase(input int n, input bit bp, input bit pe, input bit pl,
                       input int diffMode, input int burstMode, input string tag);
    for (int k = 0; k < n; k++) begin
      bit de = (diffMode == 0) ? 0 : (diffMode == 1) ? 1 : (($urandom_range(0, 15)) != 0 ? ((k / 37) % 2 == 1) : 0);
      bit be = (burstMode == 0) ? 1 : (burstMode == 1) ? 0 : ($urandom_range(0, 9) != 0);
      step($urandom_range(0, 1), $urandom_range(0, 2) != 0, be, de, bp, pe, pl, tag);
    end
  endtask

  initial begin
    // R1: outputs quiet during and just after reset
    repeat (3) @(negedge clk);
    expTag = "R1"; compare();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); expTag = "R1"; compare();
    phase(400, 1, 0, 0, 0, 0, "R2 R5 BPSK plain");
    phase(200, 1, 0, 0, 0, 1, "R4 strobe ignored while burst low");
    phase(200, 0, 0, 0, 0, 1, "R4 QPSK burst low");
    phase(600, 0, 0, 0, 0, 2, "R3 QPSK pairing");
    phase(800, 1, 0, 0, 2, 2, "R6 R7 DBPSK");
    phase(800, 0, 0, 0, 2, 2, "R8 R7 DQPSK");
    phase(1500, 1, 1, 0, 0, 2, "R9 short PN");
    phase(3000, 0, 1, 1, 0, 2, "R10 long PN");
    phase(600, 0, 1, 0, 2, 2, "R9 R8 PN with DQPSK");
    step(0, 0, 0, 0, 1, 0, 0, "R4 idle");
    step(0, 0, 0, 0, 1, 0, 0, "R4 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule